// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt and Flag Core

This block is the control and status core of a PC-style real-time clock. Software reaches it through two byte-wide port pairs: it writes a register index to an index port and then reads or writes the selected register through the matching data port. A 32.768 kHz tick input drives a prescaler. The prescaler produces a one-second update cycle, a selectable periodic interrupt with fifteen rates, and a square-wave output.

Each update cycle is announced by an update-in-progress bit. This bit rises a fixed number of ticks before the second boundary and stays high until the update has finished. When the update ends, the seconds count advances, an update-ended flag is set, and an alarm flag is set if the alarm seconds value matches. The three event flags sit in a status register together with a summary interrupt bit. Reading that register clears the flags, and the interrupt output follows the summary bit.

The calendar is reduced to a binary seconds counter. Battery-backed storage, BCD conversion and daylight-saving switching are not part of this block.

Top module: `rtc_core`

## Requirements
- R1: Address 0 is the index port and address 1 is the data port. The data port reaches these registers by index: 0 = seconds, 1 = alarm seconds, 10 = timing register, 11 = control register, 12 = status register, 13 = validity register. Every other index reads 0. The seconds, alarm and control registers read back exactly what was written to them. Index ports always read 0.
- R2: The second port pair (address 2 for index, address 3 for data) decodes no registers. Writes to address 2 leave the low index unchanged, address 3 always reads 0, and writes to address 3 change no register.
- R3: After reset, the timing, control, status, seconds and alarm registers read 0x00, the validity register reads 0x80, and both irq and sqw are low.
- R4: Bits 6:4 of the timing register select the divider mode. The value 3'b010 runs the prescaler, one step per tick. The values 3'b110 and 3'b111 hold the prescaler at zero. Every other value freezes the prescaler at its current count. While the prescaler is not running, no periodic event and no update can occur.
- R5: Bit 7 of the timing register is update-in-progress and is read-only. With the prescaler running from count zero, the bit rises after 2^PRESC_W − UIP_LEAD ticks and stays high for UIP_LEAD + UPD_LEN ticks. In the cycle where it falls, the seconds count advances by one (59 wraps to 0) and the update-ended flag (status bit 4) is set.
- R6: While control bit 7 (inhibit) is 1, no update cycle completes, update-in-progress stays low, the seconds count does not advance, and flags that are already set are kept.
- R7: Bits 3:0 of the timing register are the rate n. For n from 1 to 15, the periodic flag (status bit 6) is set once every 2^(n−1) ticks. For n = 0 it is never set.
- R8: With control bit 3 set and n ≥ 2, sqw is a square wave with period 2^(n−1) ticks and 50% duty cycle. With control bit 3 clear or n = 0, sqw is low.
- R9: At the end of each update, the alarm flag (status bit 5) is set if the alarm register equals the advanced seconds value, or if alarm bits 7:6 are both 1.
- R10: Status bit 7 is the logical OR of (bit 6 AND control bit 6), (bit 5 AND control bit 5) and (bit 4 AND control bit 4). Status bits 3:0 read 0. The irq output equals status bit 7.
- R11: A read strobe on the status register clears all three flags. A flag event in the same cycle as that read stays set. Reads of any other register have no side effect.
- R12: Writes to the status register and to the validity register change neither of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle pulse per 32.768 kHz time-base period |
| bus_addr | input | 2 | Port select: 0/1 low index/data, 2/3 high index/data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port, combinational |
| irq | output | 1 | Interrupt request, high while the summary bit is set |
| sqw | output | 1 | Square-wave output |

## Verification
The checker verifies several properties on every cycle:
- The inhibit bit keeps update-in-progress low and blocks update completion.
- A stopped or reset divider produces neither periodic nor second events.
- Every update end falls inside the update-in-progress window.
- A status read with no event clears every flag and drops irq.
- A cleared square-wave enable forces sqw low.

Some behaviours can only be shown by the directed scenarios, because they need measurements across thousands of ticks:
- the exact tick distances to the update-in-progress rise, its width and the periodic interval;
- the freeze-versus-reset difference between divider codes;
- the alarm match and don't-care cases with seconds wrap;
- the port decoding.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam logic [7:0] IDX_SEC  = 8'd0;
    localparam logic [7:0] IDX_ALM  = 8'd1;
    localparam logic [7:0] IDX_TIM  = 8'd10;
    localparam logic [7:0] IDX_CTL  = 8'd11;
    localparam logic [7:0] IDX_STS  = 8'd12;
    localparam logic [7:0] IDX_VLD  = 8'd13;

    localparam logic [2:0] DIV_RUN  = 3'b010;
    localparam logic [7:0] SEC_LAST = 8'd59;

    typedef struct packed {
        logic [7:0] idx;
        logic [2:0] div;
        logic [3:0] rate;
        logic [7:0] ctl;
        logic [7:0] sec;
        logic [7:0] alm;
        logic       sqw;
    } core_state_t;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESC_W  = 15,
    parameter int UIP_LEAD = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] div,
    input  logic [3:0] rate,
    output logic       run,
    output logic       sec_evt,
    output logic       per_evt,
    output logic       half_evt,
    output logic       lead_win
);
    localparam logic [PRESC_W-1:0] CNT_MAX    = '1;
    localparam logic [PRESC_W-1:0] LEAD_START = CNT_MAX - PRESC_W'(UIP_LEAD) + 1'b1;

    logic [PRESC_W-1:0] cnt_d, cnt_q;
    logic [PRESC_W-1:0] full_mask, half_mask;
    logic               hold_zero, rate_on;

    always_comb begin
        run       = (div == rtc_pkg::DIV_RUN);
        hold_zero = (div[2:1] == 2'b11);              // R4 reset codes
        rate_on   = (rate != 4'd0);
        for (int i = 0; i < PRESC_W; i++) begin
            full_mask[i] = (i + 1 < int'(rate));
            half_mask[i] = (i + 2 < int'(rate));
        end
        cnt_d = cnt_q;
        if (hold_zero)
            cnt_d = '0;
        else if (run && tick)
            cnt_d = cnt_q + 1'b1;
        sec_evt  = run && tick && (cnt_q == CNT_MAX);
        per_evt  = run && tick && rate_on && ((cnt_q & full_mask) == full_mask);
        half_evt = run && tick && rate_on && ((cnt_q & half_mask) == half_mask);
        lead_win = run && (cnt_q >= LEAD_START);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq #(
    parameter int UPD_LEN = 65
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic inhibit,
    input  logic sec_evt,
    input  logic lead_win,
    output logic uip,
    output logic upd_end
);
    localparam int CW = $clog2(UPD_LEN + 1);

    logic          act_d, act_q;
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        act_d   = act_q;
        cnt_d   = cnt_q;
        upd_end = 1'b0;
        if (!run || inhibit) begin                    // R6
            act_d = 1'b0;
            cnt_d = '0;
        end else if (sec_evt) begin
            act_d = 1'b1;
            cnt_d = CW'(UPD_LEN - 1);
        end else if (act_q && tick) begin
            if (cnt_q == '0) begin
                act_d   = 1'b0;
                upd_end = 1'b1;                       // R5
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
        uip = run && !inhibit && (lead_win || act_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            act_q <= act_d;
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/rtc_flags.sv
module rtc_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       set_pf,
    input  logic       set_af,
    input  logic       set_uf,
    input  logic [2:0] en,
    output logic [2:0] flags,
    output logic       irqf
);
    logic [2:0] flg_d, flg_q;

    always_comb begin
        // R11: a same-cycle event outlives the clear
        flg_d = (clr ? 3'b000 : flg_q) | {set_pf, set_af, set_uf};
        flags = flg_q;
        irqf  = |(flg_q & en);                        // R10
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= 3'b000;
        else        flg_q <= flg_d;
    end
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
    parameter int PRESC_W  = 15,
    parameter int UIP_LEAD = 8,
    parameter int UPD_LEN  = 65
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_32k,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       sqw
);
    import rtc_pkg::*;

    core_state_t st_d, st_q;

    logic       run, sec_evt, per_evt, half_evt, lead_win;
    logic       uip, upd_end, irqf, alarm_hit, rd_sts, set_any;
    logic [2:0] flags;
    logic [7:0] sec_nxt;
    logic       lo_data, wr_data, wr_idx;
    logic [7:0] ctl_view;
    logic [2:0] div_view;

    rtc_prescaler #(.PRESC_W(PRESC_W), .UIP_LEAD(UIP_LEAD)) u_presc (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k),
        .div(st_q.div), .rate(st_q.rate),
        .run(run), .sec_evt(sec_evt), .per_evt(per_evt),
        .half_evt(half_evt), .lead_win(lead_win)
    );

    rtc_update_seq #(.UPD_LEN(UPD_LEN)) u_upd (
        .clk(clk), .rst_n(rst_n), .tick(tick_32k), .run(run),
        .inhibit(st_q.ctl[7]), .sec_evt(sec_evt), .lead_win(lead_win),
        .uip(uip), .upd_end(upd_end)
    );

    rtc_flags u_flags (
        .clk(clk), .rst_n(rst_n), .clr(rd_sts),
        .set_pf(per_evt), .set_af(alarm_hit), .set_uf(upd_end),
        .en(st_q.ctl[6:4]), .flags(flags), .irqf(irqf)
    );

    always_comb begin
        lo_data   = (bus_addr == 2'b01);
        wr_data   = bus_wr && lo_data;
        wr_idx    = bus_wr && (bus_addr == 2'b00);      // R2: address 2 ignored
        rd_sts    = bus_rd && lo_data && (st_q.idx == IDX_STS);
        sec_nxt   = (st_q.sec >= SEC_LAST) ? 8'd0 : st_q.sec + 8'd1;
        alarm_hit = upd_end && ((st_q.alm[7:6] == 2'b11) || (st_q.alm == sec_nxt)); // R9
        set_any   = per_evt || upd_end;
        ctl_view  = st_q.ctl;
        div_view  = st_q.div;

        st_d = st_q;
        if (wr_idx) st_d.idx = bus_wdata;
        if (upd_end) st_d.sec = sec_nxt;
        if (wr_data) begin
            unique case (st_q.idx)
                IDX_SEC: st_d.sec = bus_wdata;
                IDX_ALM: st_d.alm = bus_wdata;
                IDX_TIM: begin
                    st_d.div  = bus_wdata[6:4];
                    st_d.rate = bus_wdata[3:0];
                end
                IDX_CTL: st_d.ctl = bus_wdata;
                default: ;                            // R12
            endcase
        end
        if (!st_q.ctl[3] || (st_q.rate == 4'd0) || !run)
            st_d.sqw = 1'b0;                          // R8
        else if (half_evt)
            st_d.sqw = !st_q.sqw;

        bus_rdata = 8'h00;
        if (lo_data) begin
            unique case (st_q.idx)
                IDX_SEC: bus_rdata = st_q.sec;
                IDX_ALM: bus_rdata = st_q.alm;
                IDX_TIM: bus_rdata = {uip, st_q.div, st_q.rate};
                IDX_CTL: bus_rdata = st_q.ctl;
                IDX_STS: bus_rdata = {irqf, flags, 4'b0000};
                IDX_VLD: bus_rdata = 8'h80;
                default: bus_rdata = 8'h00;           // R1
            endcase
        end
        irq = irqf;
        sqw = st_q.sqw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;                       // R3
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctl,
    input logic [2:0] div,
    input logic       uip,
    input logic       sqw,
    input logic       upd_end,
    input logic       per_evt,
    input logic       sec_evt,
    input logic       set_any,
    input logic       rd_sts,
    input logic [2:0] flags,
    input logic       irq
);
    AST_INHIBIT_NO_UIP: assert property (@(posedge clk) disable iff (!rst_n) ctl[7] |-> !uip); // R6
    AST_INHIBIT_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n) ctl[7] |-> !upd_end); // R6
    AST_STOPPED_NO_EVENTS: assert property (@(posedge clk) disable iff (!rst_n) (div != 3'b010) |-> !(per_evt || sec_evt)); // R4
    AST_END_INSIDE_UIP: assert property (@(posedge clk) disable iff (!rst_n) upd_end |-> uip); // R5
    AST_READ_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n) (rd_sts && !set_any) |=> (flags == 3'b000 && !irq)); // R11
    AST_SQW_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !ctl[3] |=> !sqw); // R8
endmodule

bind rtc_core rtc_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_view), .div(div_view), .uip(uip),
    .sqw(sqw), .upd_end(upd_end), .per_evt(per_evt), .sec_evt(sec_evt),
    .set_any(set_any), .rd_sts(rd_sts), .flags(flags), .irq(irq)
);

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
    localparam int PW = 12;
    localparam int LEAD = 8;
    localparam int ULEN = 65;
    localparam int SEC_TICKS = 1 << PW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [1:0] addr = 2'b00;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq, sqw;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rtc_core #(.PRESC_W(PW), .UIP_LEAD(LEAD), .UPD_LEN(ULEN)) u_rtc_core (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick), .bus_addr(addr),
        .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq(irq), .sqw(sqw)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic brd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] i, input logic [7:0] d);
        bwr(2'd0, i);
        bwr(2'd1, d);
    endtask

    task automatic reg_rd(input logic [7:0] i, output logic [7:0] d);
        bwr(2'd0, i);
        brd(2'd1, d);
    endtask

    task automatic wait_cond_irq(output int k);
        k = 0;
        while (!irq && k < 3 * SEC_TICKS) begin @(negedge clk); k++; end
    endtask

    // polls timing-register bit 7 through the data port
    task automatic measure_uip(output int rise, output int width);
        rise = 0; width = 0;
        while (!rdata[7] && rise < 2 * SEC_TICKS) begin @(negedge clk); rise++; end
        while (rdata[7] && width < 4 * ULEN) begin @(negedge clk); width++; end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        reg_rd(8'd10, v); chk("R3 timing reset", v, 8'h00);
        reg_rd(8'd11, v); chk("R3 control reset", v, 8'h00);
        reg_rd(8'd12, v); chk("R3 status reset", v, 8'h00);
        reg_rd(8'd13, v); chk("R3 validity reset", v, 8'h80);
        reg_rd(8'd0, v);  chk("R3 seconds reset", v, 8'h00);
        reg_rd(8'd1, v);  chk("R3 alarm reset", v, 8'h00);
        chk("R3 irq reset", irq, 0);
        chk("R3 sqw reset", sqw, 0);
        reg_rd(8'd5, v);  chk("R1 unmapped index", v, 8'h00);
    endtask

    task automatic t_ports();
        logic [7:0] v;
        reg_wr(8'd11, 8'h06); brd(2'd1, v); chk("R1 control readback", v, 8'h06);
        reg_wr(8'd1, 8'h2D);  brd(2'd1, v); chk("R1 alarm readback", v, 8'h2D);
        brd(2'd0, v); chk("R1 index port reads zero", v, 8'h00);
        bwr(2'd0, 8'd11);
        bwr(2'd3, 8'hFF); brd(2'd1, v); chk("R2 high data write ignored", v, 8'h06);
        brd(2'd3, v); chk("R2 high data reads zero", v, 8'h00);
        bwr(2'd2, 8'd13); brd(2'd1, v); chk("R2 high index ignored", v, 8'h06);
        reg_wr(8'd12, 8'hF0); brd(2'd1, v); chk("R12 status write ignored", v, 8'h00);
        reg_wr(8'd13, 8'h00); brd(2'd1, v); chk("R12 validity write ignored", v, 8'h80);
        reg_wr(8'd11, 8'h02);
        reg_wr(8'd1, 8'h00);
    endtask

    task automatic t_first_update();
        int rise, width;
        logic [7:0] v;
        reg_wr(8'd10, 8'h20);
        measure_uip(rise, width);
        chk("R5 uip lead from start", rise, SEC_TICKS - LEAD);
        chk("R5 uip width", width, LEAD + ULEN);
        reg_rd(8'd12, v); chk("R5 R10 update flag no irqf", v, 8'h10);
        reg_rd(8'd0, v);  chk("R5 seconds advanced", v, 8'h01);
        reg_rd(8'd12, v); chk("R11 status cleared by read", v, 8'h00);
    endtask

    task automatic t_alarm();
        int k;
        logic [7:0] v;
        reg_wr(8'd11, 8'h32);
        reg_wr(8'd1, 8'd2);
        wait_cond_irq(k);
        reg_rd(8'd12, v); chk("R9 R10 alarm match", v, 8'hB0);
        #1 chk("R11 irq drops after read", irq, 0);
        reg_wr(8'd0, 8'd59);
        reg_wr(8'd1, 8'hC5);
        wait_cond_irq(k);
        reg_rd(8'd12, v); chk("R9 alarm dont care", v, 8'hB0);
        reg_rd(8'd0, v);  chk("R5 seconds wrap", v, 8'h00);
        reg_wr(8'd1, 8'd7);
        wait_cond_irq(k);
        reg_rd(8'd12, v); chk("R9 alarm mismatch", v, 8'h90);
        reg_wr(8'd11, 8'h02);
    endtask

    task automatic t_inhibit();
        int seen;
        logic [7:0] v;
        reg_wr(8'd11, 8'h82);
        bwr(2'd0, 8'd10);
        addr = 2'd1;
        seen = 0;
        for (int i = 0; i < SEC_TICKS + 500; i++) begin
            @(negedge clk);
            if (rdata[7]) seen = 1;
        end
        chk("R6 no uip while inhibited", seen, 0);
        reg_rd(8'd0, v);  chk("R6 seconds held", v, 8'h01);
        reg_rd(8'd12, v); chk("R6 no update flag", v, 8'h00);
        reg_wr(8'd11, 8'h02);
    endtask

    task automatic t_divider();
        int rise, width;
        reg_wr(8'd10, 8'h60);
        bwr(2'd1, 8'h20);
        measure_uip(rise, width);
        chk("R4 reset code clears prescaler", rise, SEC_TICKS - LEAD);
        bwr(2'd1, 8'h70);
        bwr(2'd1, 8'h20);
        repeat (1000) @(negedge clk);
        bwr(2'd1, 8'h00);
        repeat (500) @(negedge clk);
        bwr(2'd1, 8'h20);
        measure_uip(rise, width);
        chk("R4 other code freezes prescaler", rise, SEC_TICKS - LEAD - 1001);
    endtask

    task automatic t_periodic();
        int k;
        logic [7:0] v;
        reg_wr(8'd10, 8'h2A);
        reg_wr(8'd11, 8'h42);
        bwr(2'd0, 8'd12);
        addr = 2'd1;
        k = 0;
        while (!rdata[6] && k < 2000) begin @(negedge clk); k++; end
        chk("R10 irq on periodic flag", irq, 1);
        brd(2'd1, v);
        k = 0;
        while (!rdata[6] && k < 2000) begin @(negedge clk); k++; end
        chk("R7 periodic interval rate 10", k, 511);
        reg_wr(8'd10, 8'h21);
        reg_rd(8'd12, v); chk("R7 rate 1 flag set", v[6], 1);
        #1 chk("R11 same-cycle flag kept", rdata[6], 1);
        reg_wr(8'd10, 8'h20);
        reg_rd(8'd12, v);
        repeat (100) @(negedge clk);
        chk("R7 rate 0 no periodic flag", rdata[6], 0);
        reg_wr(8'd11, 8'h02);
    endtask

    task automatic t_square();
        int hi, lo;
        reg_wr(8'd10, 8'h24);
        reg_wr(8'd11, 8'h0A);
        hi = 0; lo = 0;
        while (sqw && hi < 100) begin @(negedge clk); hi++; end
        hi = 0;
        while (!sqw && hi < 100) begin @(negedge clk); hi++; end
        hi = 0;
        while (sqw && hi < 100) begin @(negedge clk); hi++; end
        while (!sqw && lo < 100) begin @(negedge clk); lo++; end
        chk("R8 square high time", hi, 4);
        chk("R8 square low time", lo, 4);
        reg_wr(8'd11, 8'h02);
        @(negedge clk);
        chk("R8 square off when disabled", sqw, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ports();
        t_first_update();
        t_alarm();
        t_inhibit();
        t_divider();
        t_periodic();
        t_square();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule